// File: doc/BRIEF.md
# Load-Align Funnel Shift Register

This block holds the 64-bit destination of a load-align operation. On each cycle that a loaded memory element arrives, it moves the register's contents down by one element and writes the new element into the topmost element slot. Each operation picks its own element width, either one byte or one halfword. The oldest data falls off the bottom, and the register keeps a sliding window of the most recent elements, with the newest one at the top.

The loaded element is used exactly as it arrives, with no sign or zero extension. Address generation and memory access happen outside the block. A synchronous reset fills the register with ones. Until enough elements have been loaded to cover the whole register, the low slots that have not yet been filled keep those ones.

Top module: `lalign_top`

## Requirements
- R1: While `rst` is high at a rising clock edge, `dstReg` becomes all ones (0xffffffffffffffff). This holds whatever the other inputs are, and reset takes priority over a load.
- R2: On an edge where `rst` is low and `loadValid` is low, `dstReg` keeps its value. `sizeSel` and `loadElem` have no effect on that edge.
- R3: Byte mode is `sizeSel`=0. On a load edge in byte mode, the new `dstReg` equals `{loadElem[7:0], old dstReg[63:8]}`.
- R4: Halfword mode is `sizeSel`=1. On a load edge in halfword mode, the new `dstReg` equals `{loadElem[15:0], old dstReg[63:16]}`.
- R5: In byte mode, `loadElem[15:8]` is ignored.
- R6: From reset, loading the bytes 0x01 and then 0x02 gives 0x0201ffffffffffff.
- R7: From reset, loading the halfwords 0x0201, 0x0403, 0x0605 and 0x0807 gives 0x0807060504030201. Eight byte loads likewise replace every bit of the register.
- R8: The element size may change from one load to the next. Each load shifts by its own size.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high; sets the register to all ones |
| loadValid | input | 1 | A loaded element is present on this cycle |
| sizeSel | input | 1 | Element size: 0 selects a byte, 1 selects a halfword |
| loadElem | input | 16 | Loaded element; only bits [7:0] are used in byte mode |
| dstReg | output | 64 | Current value of the destination register |

## Verification
The hardest state to reach from the ports is a register that holds a mix of byte-sized and halfword-sized elements. A mixed state is the only place where a lane mux that picks the wrong source would show. The stimulus first fills the register completely with known halfwords. It then applies a byte load whose upper input byte is a conspicuous junk value, then a halfword load, then another byte load. After each of these steps, every byte lane of the register holds a distinct known value that can be checked. Reset is also asserted together with a valid load, to show that reset wins.

// File: rtl/lalign_pkg.sv
package lalign_pkg;
  typedef struct packed {
    logic clear;
    logic shiftByte;
    logic shiftHalf;
  } lalign_strobe_t;
endpackage

// File: rtl/lalign_ctrl.sv
module lalign_ctrl
  import lalign_pkg::*;
(
  input  logic           rst,
  input  logic           loadValid,
  input  logic           sizeSel,
  output lalign_strobe_t strobe
);
  // Reset outranks any load (R1); no strobe at all means hold (R2).
  always_comb begin
    strobe           = '0;
    strobe.clear     = rst;
    strobe.shiftByte = !rst && loadValid && !sizeSel;
    strobe.shiftHalf = !rst && loadValid && sizeSel;
  end
endmodule

// File: rtl/lalign_dp.sv
module lalign_dp
  import lalign_pkg::*;
#(
  parameter int REG_W  = 64,
  parameter int ELEM_W = 16,
  parameter int LANE_W = 8
) (
  input  logic              clk,
  input  lalign_strobe_t    strobe,
  input  logic [ELEM_W-1:0] loadElem,
  output logic [REG_W-1:0]  dstQ
);
  localparam int NLANE      = REG_W / LANE_W;
  localparam int HALF_LANES = ELEM_W / LANE_W;

  logic [REG_W-1:0] dstD;

  // Each byte lane chooses between hold, a one-lane shift and a two-lane shift.
  for (genvar i = 0; i < NLANE; i++) begin : g_lane
    logic [LANE_W-1:0] byteSrc;
    logic [LANE_W-1:0] halfSrc;

    if (i == NLANE - 1) begin : g_btop
      assign byteSrc = loadElem[LANE_W-1:0];      // R3, R5: only the low byte is used
    end else begin : g_blow
      assign byteSrc = dstQ[(i+1)*LANE_W +: LANE_W];
    end

    if (i >= NLANE - HALF_LANES) begin : g_htop
      assign halfSrc = loadElem[(i-(NLANE-HALF_LANES))*LANE_W +: LANE_W];  // R4
    end else begin : g_hlow
      assign halfSrc = dstQ[(i+HALF_LANES)*LANE_W +: LANE_W];
    end

    always_comb begin
      if (strobe.shiftHalf)      dstD[i*LANE_W +: LANE_W] = halfSrc;
      else if (strobe.shiftByte) dstD[i*LANE_W +: LANE_W] = byteSrc;
      else                       dstD[i*LANE_W +: LANE_W] = dstQ[i*LANE_W +: LANE_W];
    end
  end

  always_ff @(posedge clk) begin
    if (strobe.clear) dstQ <= '1;                 // R1
    else              dstQ <= dstD;
  end
endmodule

// File: rtl/lalign_top.sv
module lalign_top
  import lalign_pkg::*;
#(
  parameter int REG_W  = 64,
  parameter int ELEM_W = 16,
  parameter int LANE_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              loadValid,
  input  logic              sizeSel,
  input  logic [ELEM_W-1:0] loadElem,
  output logic [REG_W-1:0]  dstReg
);
  lalign_strobe_t strobe;

  lalign_ctrl u_ctrl (
    .rst      (rst),
    .loadValid(loadValid),
    .sizeSel  (sizeSel),
    .strobe   (strobe)
  );

  lalign_dp #(.REG_W(REG_W), .ELEM_W(ELEM_W), .LANE_W(LANE_W)) u_dp (
    .clk     (clk),
    .strobe  (strobe),
    .loadElem(loadElem),
    .dstQ    (dstReg)
  );
endmodule

// File: rtl/lalign_chk.sv
module lalign_chk #(
  parameter int REG_W  = 64,
  parameter int ELEM_W = 16,
  parameter int LANE_W = 8
) (
  input logic              clk,
  input logic              rst,
  input logic              loadValid,
  input logic              sizeSel,
  input logic [ELEM_W-1:0] loadElem,
  input logic [REG_W-1:0]  dstReg
);
  a_r1_reset_ones: assert property (@(posedge clk)
    rst |=> dstReg == {REG_W{1'b1}});

  a_r2_idle_hold: assert property (@(posedge clk) disable iff (rst)
    !loadValid |=> $stable(dstReg));

  // R3 and R5: a byte load takes only the low byte of the element
  a_r3_byte_shift: assert property (@(posedge clk) disable iff (rst)
    (loadValid && !sizeSel) |=>
      dstReg == {$past(loadElem[LANE_W-1:0]), $past(dstReg[REG_W-1:LANE_W])});

  a_r4_half_shift: assert property (@(posedge clk) disable iff (rst)
    (loadValid && sizeSel) |=>
      dstReg == {$past(loadElem), $past(dstReg[REG_W-1:ELEM_W])});
endmodule

bind lalign_top lalign_chk #(.REG_W(REG_W), .ELEM_W(ELEM_W), .LANE_W(LANE_W)) u_chk (.*);

// File: tb/sim_lalign_top.sv
`timescale 1ns/1ps
module sim_lalign_top;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        loadValid = 1'b0;
  logic        sizeSel = 1'b0;
  logic [15:0] loadElem = '0;
  logic [63:0] dstReg;

  int applied = 0;
  int bad = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;   // 250 MHz

  lalign_top u0 (.*);

  typedef struct packed {
    logic        r;
    logic        v;
    logic        s;
    logic [15:0] e;
    logic [63:0] x;
    logic [7:0]  req;
  } vec_t;

  localparam int NV = 14;
  localparam vec_t VEC [NV] = '{
    '{1'b1, 1'b0, 1'b0, 16'h0000, 64'hffffffffffffffff, 8'd1}, // R1
    '{1'b0, 1'b1, 1'b0, 16'h0001, 64'h01ffffffffffffff, 8'd3}, // R3
    '{1'b0, 1'b1, 1'b0, 16'h0002, 64'h0201ffffffffffff, 8'd6}, // R6
    '{1'b0, 1'b0, 1'b1, 16'h00aa, 64'h0201ffffffffffff, 8'd2}, // R2
    '{1'b1, 1'b0, 1'b0, 16'h0000, 64'hffffffffffffffff, 8'd1}, // R1
    '{1'b0, 1'b1, 1'b1, 16'h0201, 64'h0201ffffffffffff, 8'd4}, // R4
    '{1'b0, 1'b1, 1'b1, 16'h0403, 64'h04030201ffffffff, 8'd4}, // R4
    '{1'b0, 1'b1, 1'b1, 16'h0605, 64'h060504030201ffff, 8'd4}, // R4
    '{1'b0, 1'b1, 1'b1, 16'h0807, 64'h0807060504030201, 8'd7}, // R7
    '{1'b0, 1'b1, 1'b0, 16'hee33, 64'h3308070605040302, 8'd5}, // R5
    '{1'b0, 1'b1, 1'b1, 16'hbeef, 64'hbeef330807060504, 8'd8}, // R8
    '{1'b0, 1'b1, 1'b0, 16'h0011, 64'h11beef3308070605, 8'd8}, // R8
    '{1'b0, 1'b0, 1'b0, 16'hffff, 64'h11beef3308070605, 8'd2}, // R2
    '{1'b1, 1'b1, 1'b1, 16'h1234, 64'hffffffffffffffff, 8'd1}  // R1 reset beats load
  };

  task automatic step(input logic r, input logic v, input logic s,
                      input logic [15:0] e, input logic [63:0] x,
                      input int req);
    rst = r; loadValid = v; sizeSel = s; loadElem = e;
    @(posedge clk);
    @(negedge clk);
    applied++;
    if (dstReg !== x) begin
      bad++;
      $display("FAIL R%0d: dstReg=%h expected %h", req, dstReg, x);
    end
  endtask

  initial begin
    @(negedge clk);
    for (int k = 0; k < NV; k++)
      step(VEC[k].r, VEC[k].v, VEC[k].s, VEC[k].e, VEC[k].x, int'(VEC[k].req));

    // R1: reset held across several edges keeps the register at all ones
    for (int k = 0; k < 3; k++)
      step(1'b1, 1'b1, 1'b0, 16'h5555, 64'hffffffffffffffff, 1);

    // R7: eight byte loads replace the entire register
    begin
      logic [63:0] model = 64'hffffffffffffffff;
      for (int k = 0; k < 8; k++) begin
        model = {8'h80 + 8'(k), model[63:8]};
        step(1'b0, 1'b1, 1'b0, {8'hc3, 8'h80 + 8'(k)}, model, 7);
      end
      // final value must be 0x8786858483828180
      step(1'b0, 1'b0, 1'b0, 16'h0000, 64'h8786858483828180, 7);
    end

    // R2: a long idle run with toggling element bits leaves the value alone
    for (int k = 0; k < 4; k++)
      step(1'b0, 1'b0, 1'(k), 16'(k * 16'h1111), 64'h8786858483828180, 2);

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", applied, bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      bad++;
      $display("FAIL watchdog: run did not complete, actual hung expected done");
      $display("== %0d vectors applied, %0d miscompares ==", applied, bad);
      $finish;
    end
  end
endmodule